// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Interrupt Detection

This block is a general-purpose I/O port of sixteen pins, reached through a simple 32-bit memory-mapped register bus. The bus has a byte address, a write strobe, write data and read data. Reads are combinational from the address. Writes take effect at the next rising clock edge. The port holds the output latch, the per-pin output enables and the per-pin alternate-function selects. It also holds three per-pin interrupt controls: enable, trigger type and polarity. Every control word sits behind a pair of write-one strobes, one address to set bits and one to clear them, so software never has to read, modify and write a control word.

Pin inputs pass through a two-flop synchronizer. The synchronized value feeds the readable input data and an edge or level detector. Detected events latch into a pending-status word, which software clears by writing ones. Each pin has its own interrupt line, and a single combined line is also driven. Two byte-lane windows let software update chosen bits of one output byte in one write: the mask is carried in the address. The bus is a plain register interface with no back-pressure, and the pin-side signals are plain levels.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset the output latch, output enables, interrupt enables, types, polarities and pending status are all zero, every alternate-function bit is one, and both interrupt outputs are low.
- R2: A write to byte offset 0x000 or 0x004 loads bits [15:0] of the write data into the output latch, which drives `pin_out`. Offset 0x004 reads back the latch. Bits [31:16] of every read are zero.
- R3: Control pairs sit at set/clear offsets: output enable 0x010/0x014, alternate function 0x018/0x01C, interrupt enable 0x020/0x024, type 0x028/0x02C, polarity 0x030/0x034. A 1 at the set offset sets that bit, and a 1 at the clear offset clears it. A 0 leaves the bit unchanged, and either offset reads the current word.
- R4: Offset 0x000 reads the pin inputs through two flops. If a pin changes before clock edge k, the read shows the new value after edge k+1, and not after edge k.
- R5: In the low window (offsets 0x400–0x7FC), address bits [9:2] form a mask. A write copies write-data bits [7:0] into latch bits [7:0] only where the mask is 1. A read returns input bits [7:0] ANDed with the mask in read bits [7:0], with all other read bits zero.
- R6: In the high window (offsets 0x800–0xBFC), address bits [9:2] form a mask. A write copies write-data bits [15:8] into latch bits [15:8] only where the mask is 1. A read returns input bits [15:8] ANDed with the mask in read bits [15:8], with all other read bits zero.
- R7: With type bit 1 (edge), a rising synchronized edge sets the pending bit when polarity is 1, and a falling edge sets it when polarity is 0. The bit stays set until cleared. A pin that changes before edge k sets the pending bit at edge k+2.
- R8: With type bit 0 (level), the pending bit is set on every clock while the synchronized pin sits at its active level: high for polarity 1, low for polarity 0. A clear has no lasting effect while that level holds.
- R9: Offset 0x038 reads the pending word. A write there clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R10: When a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R11: `irq_pin[i]` is high when pending bit i and enable bit i are both 1, and `irq_any` is high when any `irq_pin` bit is high. Clearing an enable bit masks the line but keeps the pending bit readable.
- R12: A pin whose interrupt enable is 0 never sets its pending bit.
- R13: Reads of reserved or unmapped offsets (0x008, 0x00C, 0x03C, 0xC00 and above) return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Raw pin inputs, asynchronous |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Per-pin output enables |
| pin_alt | output | 16 | Per-pin alternate-function selects |
| irq_pin | output | 16 | Per-pin interrupt lines |
| irq_any | output | 1 | OR of all per-pin interrupt lines |

## Verification
The detector is tried with isolated rising and falling steps on pins of opposite polarity, so that an edge of the wrong direction that sets a bit is seen. A held active level is combined with clears written before and after the level drops; this tells level behaviour apart from edge behaviour. A clear is timed to land in the exact cycle of a new edge, which shows whether the event or the clear wins. Masked-window writes and reads use masks with mixed ones and zeros over a latch that already holds data, so untouched bits must keep their values, and a pin toggled with its enable off shows that nothing leaks into the pending word.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_AW   = 12;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned NPAIRS   = 5;
  localparam int unsigned PAIR_OE   = 0;
  localparam int unsigned PAIR_ALT  = 1;
  localparam int unsigned PAIR_EN   = 2;
  localparam int unsigned PAIR_TYPE = 3;
  localparam int unsigned PAIR_POL  = 4;

  localparam logic [BUS_AW-1:0] A_DATA  = 12'h000;
  localparam logic [BUS_AW-1:0] A_LATCH = 12'h004;
  localparam logic [BUS_AW-1:0] A_PAIR0 = 12'h010;
  localparam logic [BUS_AW-1:0] A_STAT  = 12'h038;

  // word index of a set (clr=0) or clear (clr=1) address of pair idx
  function automatic logic [BUS_AW-3:0] pair_word(int unsigned idx, bit clr);
    logic [BUS_AW-1:0] a;
    a = A_PAIR0 + BUS_AW'(idx * 8) + (clr ? BUS_AW'(4) : BUS_AW'(0));
    return a[BUS_AW-1:2];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= raw;
      sync <= meta;
      prev <= sync;
    end
  end
endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;

  assign set_m = set_we ? wdata : '0;
  assign clr_m = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_latch.sv
module gpio_latch #(
  parameter int unsigned W     = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_we,
  input  logic [LANES-1:0] lane_we,
  input  logic [LW-1:0]    lane_mask,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (full_we) nxt = wdata;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) begin
        for (int b = 0; b < LW; b++) begin
          if (lane_mask[b]) nxt[l*LW+b] = wdata[l*LW+b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] irq
);
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr_m;

  assign rise     = sync & ~prev;
  assign fall     = ~sync & prev;
  assign edge_hit = (pol & rise) | (~pol & fall);
  assign lvl_hit  = (pol & sync) | (~pol & ~sync);
  assign hit      = en & ((typ & edge_hit) | (~typ & lvl_hit));
  assign clr_m    = clr_we ? wdata : '0;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_m) | hit;
  end

  assign irq = status & en;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_DW-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_alt,
  output logic [NUM_PINS-1:0] irq_pin,
  output logic                irq_any
);
  localparam int unsigned LANES = NUM_PINS / LANE_W;
  localparam int unsigned WORD_W = BUS_AW - 2;
  localparam int unsigned LANE_SEL_W = BUS_AW - 10;

  logic [WORD_W-1:0]     word;
  logic [LANE_SEL_W-1:0] lane_sel;
  logic [LANE_W-1:0]     win_mask;
  logic [NUM_PINS-1:0]   wd;
  logic                  unused_bits;

  assign word        = bus_addr[BUS_AW-1:2];
  assign lane_sel    = bus_addr[BUS_AW-1:10];
  assign win_mask    = bus_addr[9:2];
  assign wd          = bus_wdata[NUM_PINS-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_DW-1:NUM_PINS]};

  // ---------------- synchronizer ----------------
  logic [NUM_PINS-1:0] in_sync, in_prev;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .sync(in_sync), .prev(in_prev)
  );

  // ---------------- set/clear control pairs ----------------
  logic [NUM_PINS-1:0] pair_q [NPAIRS];

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    localparam logic [NUM_PINS-1:0] RV = (i == PAIR_ALT) ? '1 : '0;
    logic s_we, c_we;
    assign s_we = bus_wr && (word == pair_word(i, 1'b0));
    assign c_we = bus_wr && (word == pair_word(i, 1'b1));
    gpio_setclr #(.W(NUM_PINS), .RST(RV)) u_reg (
      .clk(clk), .rst_n(rst_n), .set_we(s_we), .clr_we(c_we),
      .wdata(wd), .q(pair_q[i])
    );
  end

  assign pin_oe  = pair_q[PAIR_OE];
  assign pin_alt = pair_q[PAIR_ALT];

  // ---------------- output latch with byte windows ----------------
  logic             full_we;
  logic [LANES-1:0] lane_we;

  assign full_we = bus_wr && ((word == A_DATA[BUS_AW-1:2]) || (word == A_LATCH[BUS_AW-1:2]));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = bus_wr && (lane_sel == LANE_SEL_W'(l + 1));
  end

  gpio_latch #(.W(NUM_PINS), .LANES(LANES), .LW(LANE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .full_we(full_we), .lane_we(lane_we),
    .lane_mask(win_mask), .wdata(wd), .q(pin_out)
  );

  // ---------------- interrupt detection ----------------
  logic                irq_stat;
  logic [NUM_PINS-1:0] stat_q;

  assign irq_stat = bus_wr && (word == A_STAT[BUS_AW-1:2]);

  gpio_irq #(.W(NUM_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sync(in_sync), .prev(in_prev),
    .en(pair_q[PAIR_EN]), .typ(pair_q[PAIR_TYPE]), .pol(pair_q[PAIR_POL]),
    .clr_we(irq_stat), .wdata(wd), .status(stat_q), .irq(irq_pin)
  );

  assign irq_any = |irq_pin;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (word == A_DATA[BUS_AW-1:2])       bus_rdata[NUM_PINS-1:0] = in_sync;
    else if (word == A_LATCH[BUS_AW-1:2]) bus_rdata[NUM_PINS-1:0] = pin_out;
    else if (word == A_STAT[BUS_AW-1:2])  bus_rdata[NUM_PINS-1:0] = stat_q;
    for (int i = 0; i < NPAIRS; i++) begin
      if (word == pair_word(i, 1'b0) || word == pair_word(i, 1'b1))
        bus_rdata[NUM_PINS-1:0] = pair_q[i];
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_sel == LANE_SEL_W'(l + 1))
        bus_rdata[l*LANE_W +: LANE_W] = in_sync[l*LANE_W +: LANE_W] & win_mask;
    end
  end
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
  import gpio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic [15:0]       pin_out,
  input logic [15:0]       pin_oe,
  input logic [15:0]       pin_alt,
  input logic [15:0]       st
);
  logic oe_set, oe_clr, st_wr, latch_wr;
  assign oe_set   = bus_wr && (bus_addr[11:2] == 10'h004);
  assign oe_clr   = bus_wr && (bus_addr[11:2] == 10'h005);
  assign st_wr    = bus_wr && (bus_addr[11:2] == 10'h00E);
  assign latch_wr = bus_wr && (bus_addr[11:2] == 10'h000 || bus_addr[11:2] == 10'h001
                               || bus_addr[11:10] != 2'b00);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_alt == 16'hFFFF && pin_out == 16'h0 && pin_oe == 16'h0 && st == 16'h0));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr |=> $stable(pin_out));

  p_oe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_set |=> ((pin_oe & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0])));

  p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_clr |=> ((pin_oe & $past(bus_wdata[15:0])) == 16'h0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> (($past(st) & ~st) == 16'h0));
endmodule

bind gpio_port_irq gpio_port_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_alt(pin_alt), .st(stat_q)
);

// File: tb/gpio_port_irq_test.sv
`timescale 1ns/1ps
module gpio_port_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_alt, irq_pin;
  logic        irq_any;

  int n_run = 0;
  int n_fail = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  gpio_port_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt),
    .irq_pin(irq_pin), .irq_any(irq_any)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_out, m_oe, m_alt, m_en, m_typ, m_pol, m_st;
  logic [15:0] hist[$];

  function automatic logic [15:0] m_in();
    return hist[hist.size()-2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_oe = 0; m_alt = 16'hFFFF; m_en = 0; m_typ = 0; m_pol = 0; m_st = 0;
      hist = '{16'h0, 16'h0, 16'h0};
    end else begin
      logic [15:0] cur, old, ev, clr, d;
      int w;
      cur = hist[hist.size()-2];
      old = hist[hist.size()-3];
      ev = 0;
      for (int b = 0; b < 16; b++) begin
        if (m_en[b]) begin
          if (m_typ[b]) begin
            if (m_pol[b] && cur[b] && !old[b]) ev[b] = 1;
            if (!m_pol[b] && !cur[b] && old[b]) ev[b] = 1;
          end else if (cur[b] == m_pol[b]) ev[b] = 1;
        end
      end
      clr = 0;
      d = bus_wdata[15:0];
      w = int'(bus_addr) / 4;
      if (bus_wr) begin
        if (w == 0 || w == 1) m_out = d;
        else if (w == 4) m_oe = m_oe | d;
        else if (w == 5) m_oe = m_oe & ~d;
        else if (w == 6) m_alt = m_alt | d;
        else if (w == 7) m_alt = m_alt & ~d;
        else if (w == 8) m_en = m_en | d;
        else if (w == 9) m_en = m_en & ~d;
        else if (w == 10) m_typ = m_typ | d;
        else if (w == 11) m_typ = m_typ & ~d;
        else if (w == 12) m_pol = m_pol | d;
        else if (w == 13) m_pol = m_pol & ~d;
        else if (w == 14) clr = d;
        else if (bus_addr >= 12'h400 && bus_addr < 12'h800) begin
          for (int b = 0; b < 8; b++) if (bus_addr[2+b]) m_out[b] = d[b];
        end else if (bus_addr >= 12'h800 && bus_addr < 12'hC00) begin
          for (int b = 0; b < 8; b++) if (bus_addr[2+b]) m_out[8+b] = d[8+b];
        end
      end
      m_st = (m_st & ~clr) | ev;
      hist.push_back(pin_in);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] m_rd(logic [11:0] a);
    logic [15:0] v;
    int w;
    w = int'(a) / 4;
    v = 0;
    case (w)
      0: v = m_in();
      1: v = m_out;
      4, 5: v = m_oe;
      6, 7: v = m_alt;
      8, 9: v = m_en;
      10, 11: v = m_typ;
      12, 13: v = m_pol;
      14: v = m_st;
      default: begin
        if (a >= 12'h400 && a < 12'h800) v = {8'h0, m_in() & 16'(a[9:2])} & 16'h00FF;
        else if (a >= 12'h800 && a < 12'hC00) v = {m_in()[15:8] & a[9:2], 8'h0};
      end
    endcase
    return {16'h0, v};
  endfunction

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R2 pin_out vs model", 32'(pin_out), 32'(m_out));
      chk("R3 pin_oe vs model", 32'(pin_oe), 32'(m_oe));
      chk("R3 pin_alt vs model", 32'(pin_alt), 32'(m_alt));
      chk("R11 irq_pin vs model", 32'(irq_pin), 32'(m_st & m_en));
      chk("R11 irq_any vs model", 32'(irq_any), 32'(|(m_st & m_en)));
      chk("R13 bus_rdata vs model", bus_rdata, m_rd(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(logic [11:0] a, logic we, logic [31:0] d);
    bus_addr = a; bus_wr = we; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(a, 1'b1, d);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    step(a, 1'b0, 32'h0);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(12'h000, 1'b0, 32'h0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    running = 1'b1;
    // R1 reset state
    chk("R1 pin_out reset", 32'(pin_out), 32'h0);
    chk("R1 pin_alt reset", 32'(pin_alt), 32'hFFFF);
    chk("R1 irq_any reset", 32'(irq_any), 32'h0);
    rd(12'h018, 32'h0000FFFF, "R1 alt readback");
    rd(12'h038, 32'h0, "R1 status reset");
    // R2 latch
    wr(12'h000, 32'hDEAD1234);
    chk("R2 write at 0x000", 32'(pin_out), 32'h1234);
    rd(12'h004, 32'h00001234, "R2 latch readback upper zero");
    wr(12'h004, 32'hFFFF5678);
    chk("R2 write at 0x004", 32'(pin_out), 32'h5678);
    // R3 set/clear
    wr(12'h010, 32'h00F0);
    wr(12'h014, 32'h0030);
    wr(12'h010, 32'h0000);
    chk("R3 oe set/clear", 32'(pin_oe), 32'h00C0);
    rd(12'h014, 32'h000000C0, "R3 read at clear offset");
    wr(12'h01C, 32'hFFFF);
    chk("R3 alt cleared", 32'(pin_alt), 32'h0);
    // R5 / R6 masked writes
    wr(12'h400 | (12'hA5 << 2), 32'h00FF);
    chk("R5 low window write", 32'(pin_out), 32'h56FD);
    wr(12'h800 | (12'h0F << 2), 32'h0000AB00);
    chk("R6 high window write", 32'(pin_out), 32'h5BFD);
    // R4 synchronizer latency
    pin_in = 16'h5A5A;
    step(12'h000, 1'b0, 0);
    chk("R4 not yet visible", bus_rdata, 32'h0);
    step(12'h000, 1'b0, 0);
    chk("R4 visible after two edges", bus_rdata, 32'h5A5A);
    rd(12'h400 | (12'h0F << 2), 32'h0000000A, "R5 low window read");
    rd(12'h800 | (12'hF0 << 2), 32'h00005000, "R6 high window read");
    pin_in = 16'h0;
    idle(3);
    // R7 edge detection
    wr(12'h028, 32'h0003);
    wr(12'h030, 32'h0005);
    wr(12'h020, 32'h0007);
    pin_in[0] = 1'b1;
    idle(2);
    chk("R7 rising not before edge k+2", 32'(irq_pin), 32'h0);
    idle(1);
    chk("R7 rising edge latched", 32'(irq_pin), 32'h1);
    chk("R11 irq_any high", 32'(irq_any), 32'h1);
    pin_in[1] = 1'b1;
    idle(3);
    chk("R7 rise ignored on falling pin", 32'(irq_pin), 32'h1);
    pin_in[1] = 1'b0;
    idle(3);
    chk("R7 falling edge latched", 32'(irq_pin), 32'h3);
    // R9 clear
    wr(12'h038, 32'h0001);
    chk("R9 clear bit0", 32'(irq_pin), 32'h2);
    wr(12'h038, 32'h0000);
    rd(12'h038, 32'h00000002, "R9 zero write no effect");
    wr(12'h038, 32'h0002);
    chk("R9 clear bit1", 32'(irq_pin), 32'h0);
    // R8 level
    pin_in[2] = 1'b1;
    idle(3);
    chk("R8 level set", 32'(irq_pin), 32'h4);
    wr(12'h038, 32'h0004);
    chk("R8 clear while active", 32'(irq_pin), 32'h4);
    pin_in[2] = 1'b0;
    idle(3);
    chk("R8 held after level drops", 32'(irq_pin), 32'h4);
    wr(12'h038, 32'h0004);
    chk("R8 cleared after drop", 32'(irq_pin), 32'h0);
    // R10 event beats clear
    pin_in[0] = 1'b0;
    idle(3);
    pin_in[0] = 1'b1;
    idle(2);
    wr(12'h038, 32'h0001);
    chk("R10 event wins over clear", 32'(irq_pin), 32'h1);
    wr(12'h038, 32'h0001);
    // R12 disabled pin
    wr(12'h028, 32'h0008);
    wr(12'h030, 32'h0008);
    pin_in[3] = 1'b1;
    idle(3);
    rd(12'h038, 32'h0, "R12 disabled pin no status");
    // R11 gating by enable
    pin_in[0] = 1'b0;
    idle(3);
    pin_in[0] = 1'b1;
    idle(3);
    wr(12'h024, 32'h0001);
    chk("R11 masked line", 32'(irq_pin), 32'h0);
    chk("R11 masked any", 32'(irq_any), 32'h0);
    rd(12'h038, 32'h00000001, "R11 status kept");
    // R13 reserved
    wr(12'h008, 32'hFFFFFFFF);
    wr(12'hC00, 32'hFFFFFFFF);
    rd(12'h008, 32'h0, "R13 reserved 0x008");
    rd(12'h00C, 32'h0, "R13 reserved 0x00C");
    rd(12'h03C, 32'h0, "R13 reserved 0x03C");
    rd(12'hC00, 32'h0, "R13 unmapped 0xC00");
    chk("R13 latch untouched", 32'(pin_out), 32'h5BFD);
    idle(2);
    running = 1'b0;
    summary();
  end
endmodule